// File: doc/BRIEF.md
# Branch Misprediction Check and Flush Controller

This block sits in the instruction decode stage. It keeps the predictions that fetch made and checks them against the branch outcomes that arrive later from the execute stage. Fetch hands over one prediction per cycle: a taken bit and a predicted target. Each prediction goes into an in-order queue that holds up to `DEPTH` entries. When the execute stage reports a resolved branch (its PC, actual direction and actual target), the controller takes the oldest queued prediction out of the queue and compares it with the outcome.

If the two disagree, the controller sends the rest of the pipeline a one-cycle flush pulse together with the PC that fetch must restart from. It also discards every younger prediction still queued, including one that arrives in the same cycle. A full queue stalls fetch through a level output. An outcome that arrives with nothing queued raises a one-cycle error pulse and causes no flush.

Top module: `mispred_flush_ctrl`

## Requirements
- R1: A prediction offered with `predValid` high is stored when `predFull` is low at that clock edge. `predFull` is high exactly when `DEPTH` (default 8) predictions are stored.
- R2: Every resolve update is compared with the oldest stored prediction, and that prediction is removed, so predictions are consumed in the order they were offered.
- R3: A mismatch means the taken bits differ, or both are taken (1) and the targets differ. When both are not-taken (0), the targets are ignored.
- R4: A mismatch raises `flushOut` for exactly one cycle, in the cycle after the update's clock edge. A match raises nothing.
- R5: During a flush pulse, `redirectPc` equals the resolved target if the branch was actually taken, and `updPc + 4` otherwise. At all other times it is 0.
- R6: On a mismatch, every stored prediction and any prediction offered in the same cycle are discarded, so the queue is empty in the following cycle.
- R7: An update that arrives while the queue is empty raises `updErr` for one cycle, in the next cycle, with no flush. A prediction offered in that same cycle is still stored.
- R8: A prediction offered while `predFull` is high is dropped and does not change the stored contents.
- R9: While `rstN` is low the queue is emptied and `flushOut`, `redirectPc`, `updErr` and `predFull` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| predValid | input | 1 | Fetch offers a prediction |
| predTaken | input | 1 | Predicted direction, 1 = taken |
| predTarget | input | ADDR_W | Predicted target PC |
| predFull | output | 1 | Queue full, fetch must stall |
| updValid | input | 1 | Resolve update from execute |
| updPc | input | ADDR_W | PC of the resolved branch |
| updTaken | input | 1 | Actual direction, 1 = taken |
| updTarget | input | ADDR_W | Actual target PC |
| flushOut | output | 1 | One-cycle pipeline flush pulse |
| redirectPc | output | ADDR_W | Restart PC during the flush pulse, else 0 |
| updErr | output | 1 | One-cycle pulse: update arrived with the queue empty |

## Verification
The assertions assume that reset is held for at least one clock edge before any prediction or update is offered, and that updates carry no X values while `updValid` is high. They do not assume that fetch honours `predFull`. The bench relies on this: it deliberately offers predictions into a full queue and sends updates into an empty one. All stimulus is driven half a cycle away from the active edge, so every check compares settled values.

// File: rtl/mispred_pkg.sv
package mispred_pkg;

  // Strobes issued by the control unit to the datapath for one cycle
  typedef struct packed {
    logic push;      // store the offered prediction
    logic pop;       // retire the oldest prediction
    logic clear;     // discard every stored prediction
    logic flushSet;  // load the flush pulse and the redirect PC
    logic errSet;    // load the empty-update error pulse
  } ctrlStrobes_t;

endpackage

// File: rtl/mispred_ctrl.sv
module mispred_ctrl
  import mispred_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              predValid,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              headTaken,
  input  logic [ADDR_W-1:0] headTarget,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output ctrlStrobes_t      strobes
);

  logic dirDiffers;
  logic tgtDiffers;
  logic mismatch;
  logic checkNow;

  always_comb begin
    checkNow   = updValid && !fifoEmpty;
    dirDiffers = headTaken != updTaken;
    tgtDiffers = headTaken && updTaken && (headTarget != updTarget);
    mismatch   = checkNow && (dirDiffers || tgtDiffers);

    strobes          = '0;
    strobes.pop      = checkNow;
    strobes.clear    = mismatch;
    strobes.flushSet = mismatch;
    strobes.errSet   = updValid && fifoEmpty;
    // a prediction younger than a mispredicted branch is discarded too
    strobes.push     = predValid && !fifoFull && !mismatch;
  end

endmodule

// File: rtl/mispred_datapath.sv
module mispred_datapath
  import mispred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              predTaken,
  input  logic [ADDR_W-1:0] predTarget,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              headTaken,
  output logic [ADDR_W-1:0] headTarget,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic              flushOut,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              updErr
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  takenMem;
  logic [ADDR_W-1:0] targetMem [DEPTH];
  logic [PTR_W:0]    wrPtr;
  logic [PTR_W:0]    rdPtr;

  always_comb begin
    fifoCount  = wrPtr - rdPtr;
    fifoEmpty  = wrPtr == rdPtr;
    fifoFull   = fifoCount == (PTR_W+1)'(DEPTH);
    headTaken  = takenMem[rdPtr[PTR_W-1:0]];
    headTarget = targetMem[rdPtr[PTR_W-1:0]];
  end

  // storage needs no reset: occupancy is defined by the pointers
  always_ff @(posedge clk) begin
    if (strobes.push) begin
      takenMem[wrPtr[PTR_W-1:0]]  <= predTaken;
      targetMem[wrPtr[PTR_W-1:0]] <= predTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobes.clear) begin
      rdPtr <= wrPtr;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + 1'b1;
      if (strobes.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushOut   <= 1'b0;
      redirectPc <= '0;
      updErr     <= 1'b0;
    end else begin
      flushOut   <= strobes.flushSet;
      updErr     <= strobes.errSet;
      if (strobes.flushSet)
        redirectPc <= updTaken ? updTarget : updPc + ADDR_W'(4);
      else
        redirectPc <= '0;
    end
  end

endmodule

// File: rtl/mispred_flush_ctrl.sv
module mispred_flush_ctrl
  import mispred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predValid,
  input  logic              predTaken,
  input  logic [ADDR_W-1:0] predTarget,
  output logic              predFull,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              flushOut,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              updErr
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  ctrlStrobes_t      strobes;
  logic              headTaken;
  logic [ADDR_W-1:0] headTarget;
  logic              fifoFull;
  logic              fifoEmpty;
  logic [CNT_W-1:0]  fifoCount;

  mispred_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .predValid (predValid),
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updTarget (updTarget),
    .headTaken (headTaken),
    .headTarget(headTarget),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .strobes   (strobes)
  );

  mispred_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .predTaken (predTaken),
    .predTarget(predTarget),
    .updPc     (updPc),
    .updTaken  (updTaken),
    .updTarget (updTarget),
    .headTaken (headTaken),
    .headTarget(headTarget),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .fifoCount (fifoCount),
    .flushOut  (flushOut),
    .redirectPc(redirectPc),
    .updErr    (updErr)
  );

  assign predFull = fifoFull;

endmodule

// File: rtl/mispred_flush_sva.sv
module mispred_flush_sva #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     predValid,
  input logic                     predFull,
  input logic                     updValid,
  input logic [ADDR_W-1:0]        updPc,
  input logic                     updTaken,
  input logic [ADDR_W-1:0]        updTarget,
  input logic                     flushOut,
  input logic [ADDR_W-1:0]        redirectPc,
  input logic                     updErr,
  input logic                     fifoEmpty,
  input logic [$clog2(DEPTH):0]   fifoCount
);

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= ($clog2(DEPTH)+1)'(DEPTH));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    predFull && predValid && !updValid |=> $stable(fifoCount));

  // R4
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !flushOut);

  // R5
  redirect_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid && !fifoEmpty && updTaken |=> !flushOut || redirectPc == $past(updTarget));

  // R5
  redirect_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid && !fifoEmpty && !updTaken |=> !flushOut || redirectPc == $past(updPc) + ADDR_W'(4));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> fifoEmpty);

  // R7
  empty_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid && fifoEmpty |=> updErr && !flushOut);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    updErr |-> !flushOut);

endmodule

bind mispred_flush_ctrl mispred_flush_sva #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .predValid (predValid),
  .predFull  (predFull),
  .updValid  (updValid),
  .updPc     (updPc),
  .updTaken  (updTaken),
  .updTarget (updTarget),
  .flushOut  (flushOut),
  .redirectPc(redirectPc),
  .updErr    (updErr),
  .fifoEmpty (fifoEmpty),
  .fifoCount (fifoCount)
);

// File: tb/sim_mispred_flush_ctrl.sv
module sim_mispred_flush_ctrl;

  localparam int AW = 32;
  localparam int QD = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          predValid, predTaken;
  logic [AW-1:0] predTarget;
  logic          predFull;
  logic          updValid, updTaken;
  logic [AW-1:0] updPc, updTarget;
  logic          flushOut;
  logic [AW-1:0] redirectPc;
  logic          updErr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model
  bit          mTaken[$];
  logic [AW-1:0] mTarget[$];
  bit          eFlush, eErr;
  logic [AW-1:0] eRedir;

  always #10 clk = ~clk;   // 50 MHz

  mispred_flush_ctrl #(.ADDR_W(AW), .DEPTH(QD)) u0 (
    .clk(clk), .rstN(rstN),
    .predValid(predValid), .predTaken(predTaken), .predTarget(predTarget),
    .predFull(predFull),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
    .flushOut(flushOut), .redirectPc(redirectPc), .updErr(updErr)
  );

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      summary();
    end
  end

  // One cycle: drive, check stall flag, clock, model, check outputs.
  task automatic step(bit pv, bit pt, logic [AW-1:0] ptg,
                      bit uv, logic [AW-1:0] upc, bit ut, logic [AW-1:0] utg,
                      string tag = "");
    bit full, mis, ht;
    logic [AW-1:0] htg;
    predValid = pv; predTaken = pt; predTarget = ptg;
    updValid = uv; updPc = upc; updTaken = ut; updTarget = utg;
    full = mTaken.size() == QD;
    #1 chk({tag, " R1 predFull"}, AW'(predFull), AW'(full));
    @(posedge clk);
    eFlush = 0; eErr = 0; eRedir = '0; mis = 0;
    if (uv) begin
      if (mTaken.size() == 0) eErr = 1;
      else begin
        ht  = mTaken.pop_front();
        htg = mTarget.pop_front();
        mis = (ht != ut) || (ut && htg != utg);
        if (mis) begin
          eFlush = 1;
          eRedir = ut ? utg : upc + 4;
          mTaken.delete(); mTarget.delete();
        end
      end
    end
    if (pv && !full && !mis) begin
      mTaken.push_back(pt); mTarget.push_back(ptg);
    end
    @(negedge clk);
    chk({tag, " R4 flushOut"}, AW'(flushOut), AW'(eFlush));
    chk({tag, " R5 redirectPc"}, redirectPc, eRedir);
    chk({tag, " R7 updErr"}, AW'(updErr), AW'(eErr));
  endtask

  task automatic push(bit t, logic [AW-1:0] tg, string tag = "");
    step(1, t, tg, 0, '0, 0, '0, tag);
  endtask

  task automatic upd(logic [AW-1:0] pc, bit t, logic [AW-1:0] tg, string tag = "");
    step(0, 0, '0, 1, pc, t, tg, tag);
  endtask

  task automatic idle();
    step(0, 0, '0, 0, '0, 0, '0);
  endtask

  initial begin
    rstN = 0;
    predValid = 0; predTaken = 0; predTarget = '0;
    updValid = 0; updTaken = 0; updPc = '0; updTarget = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 flushOut", AW'(flushOut), 0);
    chk("R9 redirectPc", redirectPc, 0);
    chk("R9 updErr", AW'(updErr), 0);
    chk("R9 predFull", AW'(predFull), 0);
    rstN = 1;
    idle();

    // loop pattern: taken three times, then falls through (mispredict)
    for (int i = 0; i < 4; i++) push(1, 32'h100);
    for (int i = 0; i < 3; i++) upd(32'h140, 1, 32'h100, "R2 loop");
    upd(32'h140, 0, 32'h300, "R3 loop exit");   // redirect 0x144
    upd(32'h0, 0, 32'h0, "R6 after flush");     // queue empty -> error

    // R3: both taken, different target -> flush
    push(1, 32'h200);
    upd(32'h1f0, 1, 32'h280, "R3 target");
    // R3: both not-taken, different target -> no flush
    push(0, 32'h500);
    upd(32'h4f0, 0, 32'h600, "R3 nt ignore");
    // not-taken predicted, taken actual
    push(0, 32'h0);
    upd(32'h700, 1, 32'h800, "R3 dir");

    // R1/R8: fill, offer extra, drain in order
    for (int i = 0; i < QD; i++) push(i[0], 32'h1000 + i*16);
    push(1, 32'hdead0, "R8 offered when full");
    for (int i = 0; i < QD; i++) upd(32'h2000, i[0], 32'h1000 + i*16, "R2 drain");
    upd(32'h0, 1, 32'hdead0, "R8 no extra entry");

    // R7: update on empty with same-cycle push keeps the push
    step(1, 1, 32'h900, 1, 32'h10, 1, 32'h900, "R7 push kept");
    upd(32'h10, 1, 32'h900, "R7 stored entry");

    // R6: mismatch with same-cycle push discards the push
    push(1, 32'ha00);
    push(1, 32'ha10);
    step(1, 1, 32'ha20, 1, 32'h20, 0, 32'h0, "R6 same-cycle push");
    upd(32'h0, 1, 32'ha10, "R6 younger gone");

    // full and simultaneous update with match: offered push dropped
    for (int i = 0; i < QD; i++) push(1, 32'hb00);
    step(1, 1, 32'hc00, 1, 32'h30, 1, 32'hb00, "R8 full with update");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit pv = ($urandom % 3) != 0;
      bit uv = ($urandom % 3) == 0;
      step(pv, 1'($urandom), 32'h4000 + (($urandom % 2) << 4),
           uv, 32'h8000 + ($urandom % 64) * 4, 1'($urandom),
           32'h4000 + (($urandom % 2) << 4), "rand");
    end

    done = 1;
    summary();
  end

endmodule